// File: doc/BRIEF.md
# Bit-Serial Booth Multiply-Accumulate Grid

This block computes a small signed integer matrix product, C = A x W, on a two-dimensional grid of identical bit-serial multiply-accumulate cells. Row operands A[i][k] and column operands W[k][j] are captured in parallel on a start pulse. Each captured word is then turned into a serial stream: one stream per grid column carries W bits most-significant-first downward, and one stream per grid row carries A bits least-significant-first to the right. One-bit pipeline registers sit between neighbouring cells. Column j is launched j cycles late and row i is launched i cycles late, so matching bits reach every cell in the same cycle.

Inside a cell, the incoming W word is shifted into a local register. One word-period later, the A bits drive one radix-2 Booth step per cycle. Each step compares the current multiplier bit with the previous one (the previous bit is taken as 0 for the first step) and then adds, subtracts or keeps a running multiplicand that doubles every step. Every cell adds DEPTH products into its own accumulator, which is wide enough to hold the exact sum.

The precision B is set at run time, from 1 to WMAX bits, and the run length grows with B. When every cell has its final value, a read token visits the cells one per cycle. It follows a snake path and places each accumulator on the result port.

Top module: `bcs_booth_grid`

## Requirements
- R1: After reset, busy, res_valid and done are all 0.
- R2: Each result equals the exact signed sum over k of A[i][k]*W[k][j]. A[i][k] is the field at bits (i*DEPTH+k)*WMAX of opa_flat and W[k][j] is the field at bits (k*COLS+j)*WMAX of opw_flat. Both are read as B-bit two's complement values.
- R3: Only the low B bits of each WMAX-bit operand field are used. Bits above B have no effect on any result.
- R4: The prec input is captured at an accepted start. A value of 0 runs as B=1, and any value above WMAX runs as B=WMAX.
- R5: The first res_valid is seen exactly (DEPTH+1)*B+ROWS+COLS clock edges after the edge that samples the accepted start.
- R6: Results arrive on ROWS*COLS consecutive cycles in snake order. Even rows go by ascending column and odd rows go by descending column. Rows are taken in ascending order.
- R7: One cycle after the last result, busy falls and done rises. done holds until the next accepted start, and done is never high while busy is high.
- R8: A start pulse while busy is ignored. It does not change the operands, the precision, the results or the timing of the run in progress.
- R9: The accumulator does not wrap. A sum of DEPTH products of -2^(B-1) by -2^(B-1) at B=WMAX comes out exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted only when idle |
| prec | input | PW (5) | Requested operand precision B |
| opa_flat | input | ROWS*DEPTH*WMAX (256) | Row operands A, captured at start |
| opw_flat | input | DEPTH*COLS*WMAX (256) | Column operands W, captured at start |
| busy | output | 1 | High from accepted start until readout completes |
| res_valid | output | 1 | res_data holds one cell result |
| res_data | output | ACCW (35) | Signed accumulator value of the visited cell |
| done | output | 1 | Readout finished, held until next start |

## Verification
The bench targets the most negative operand squared at full precision. A cell that loses the sign of its last Booth step, or that uses an accumulator that is too narrow, returns a wrapped or negated sum there. Runs at precision 1, at 5, and at the clamped values 0 and 31 use fields whose upper bits are random, so a cell that sign-extends from the wrong bit, or a loader that starts its word at the wrong bit, produces wrong products. The bench also counts the edges from start to the first result; a skew or drain count that is off by one shows up as a latency mismatch or as partly accumulated values. A second start is pulsed in the middle of one run with different operands and precision, so a design that reloads while busy corrupts that scoreboard.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_READ  = 2'd3
    } bcs_state_e;

    // Limit a requested precision to the supported range 1..wmax.
    function automatic int clamp_prec(input int p, input int wmax);
        if (p < 1)
            return 1;
        else if (p > wmax)
            return wmax;
        else
            return p;
    endfunction

endpackage

// File: rtl/bcs_feed.sv
// Operand loader: holds DEPTH words and serializes one of them per word-period.
// Column variant: MSb-first, words 0..DEPTH-1 in periods 0..DEPTH-1.
// Row variant: LSb-first, word k in period k+1, with a first-bit marker.
// The output is delayed SKEW cycles to line the streams up across the grid.
module bcs_feed #(
    parameter int IS_ROW = 0,
    parameter int SKEW   = 0,
    parameter int WMAX   = 16,
    parameter int DEPTH  = 4,
    parameter int KW     = 3,
    parameter int PW     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap,
    input  logic [DEPTH*WMAX-1:0]   words_i,
    input  logic                    stream,
    input  logic [KW-1:0]           kidx,
    input  logic [PW-1:0]           bidx,
    input  logic [PW-1:0]           bw,
    output logic                    bit_o,
    output logic                    v_o,
    output logic                    fst_o
);
    localparam int SKW = (SKEW > 0) ? SKEW : 1;

    typedef struct packed {
        logic [DEPTH-1:0][WMAX-1:0] words;
        logic [SKW-1:0][2:0]        sh;
    } feed_t;

    feed_t r_d, r_q;
    logic  [WMAX-1:0] wsel;
    logic  [2:0]      lane;

    always_comb begin
        int ki;
        int bp;
        logic v;
        logic b;
        r_d  = r_q;
        if (cap)
            r_d.words = words_i;
        if (IS_ROW != 0) begin
            ki = int'(kidx) - 1;
            v  = stream && (kidx != '0) && (int'(kidx) <= DEPTH);
            bp = int'(bidx);
        end else begin
            ki = int'(kidx);
            v  = stream && (int'(kidx) < DEPTH);
            bp = int'(bw) - 1 - int'(bidx);
        end
        wsel = '0;
        for (int k = 0; k < DEPTH; k++)
            if (k == ki) wsel = r_q.words[k];
        b = 1'b0;
        for (int i = 0; i < WMAX; i++)
            if (i == bp) b = wsel[i];
        lane = {b & v, v, v && (IS_ROW != 0) && (bidx == '0)};
        r_d.sh[0] = lane;
        for (int s = 1; s < SKW; s++)
            r_d.sh[s] = r_q.sh[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    generate
        if (SKEW == 0) begin : g_noskew
            assign {bit_o, v_o, fst_o} = lane;
        end else begin : g_skew
            assign {bit_o, v_o, fst_o} = r_q.sh[SKEW-1];
        end
    endgenerate

endmodule

// File: rtl/bcs_cell.sv
// One grid cell: collects the MSb-first multiplicand, then performs one
// radix-2 Booth step per LSb-first multiplier bit into a local accumulator.
module bcs_cell #(
    parameter int WMAX = 16,
    parameter int ACCW = 35,
    parameter int PW   = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic [PW-1:0]   bw,
    input  logic            c_bit_i,
    input  logic            c_v_i,
    input  logic            r_bit_i,
    input  logic            r_act_i,
    input  logic            r_fst_i,
    output logic            c_bit_o,
    output logic            c_v_o,
    output logic            r_bit_o,
    output logic            r_act_o,
    output logic            r_fst_o,
    output logic [ACCW-1:0] acc_o
);
    typedef struct packed {
        logic [WMAX-1:0] sreg;
        logic [ACCW-1:0] msh;
        logic            prev;
        logic [ACCW-1:0] acc;
        logic            cb;
        logic            cv;
        logic            rb;
        logic            ra;
        logic            rf;
    } cell_t;

    cell_t r_d, r_q;
    logic  [ACCW-1:0] ext;
    logic  [ACCW-1:0] term;

    always_comb begin
        logic sgn;
        logic pv;
        r_d    = r_q;
        r_d.cb = c_bit_i;
        r_d.cv = c_v_i;
        r_d.rb = r_bit_i;
        r_d.ra = r_act_i;
        r_d.rf = r_fst_i;
        // sign-extend the low bw bits of the collected word
        sgn = 1'b0;
        for (int b = 0; b < WMAX; b++)
            if (b == int'(bw) - 1) sgn = r_q.sreg[b];
        for (int b = 0; b < WMAX; b++)
            ext[b] = (b < int'(bw)) ? r_q.sreg[b] : sgn;
        for (int b = WMAX; b < ACCW; b++)
            ext[b] = sgn;
        if (c_v_i)
            r_d.sreg = {r_q.sreg[WMAX-2:0], c_bit_i};
        term = r_fst_i ? ext : r_q.msh;
        pv   = r_fst_i ? 1'b0 : r_q.prev;
        if (r_act_i) begin
            case ({r_bit_i, pv})
                2'b10:   r_d.acc = r_q.acc - term;
                2'b01:   r_d.acc = r_q.acc + term;
                default: r_d.acc = r_q.acc;
            endcase
            r_d.prev = r_bit_i;
            r_d.msh  = term << 1;
        end
        if (clr) begin
            r_d.acc  = '0;
            r_d.prev = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign c_bit_o = r_q.cb;
    assign c_v_o   = r_q.cv;
    assign r_bit_o = r_q.rb;
    assign r_act_o = r_q.ra;
    assign r_fst_o = r_q.rf;
    assign acc_o   = r_q.acc;

endmodule

// File: rtl/bcs_booth_grid.sv
module bcs_booth_grid #(
    parameter  int ROWS  = 4,
    parameter  int COLS  = 4,
    parameter  int DEPTH = 4,
    parameter  int WMAX  = 16,
    localparam int PW    = $clog2(WMAX + 1),
    localparam int ACCW  = 2 * WMAX + $clog2(DEPTH + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [PW-1:0]               prec,
    input  logic [ROWS*DEPTH*WMAX-1:0]  opa_flat,
    input  logic [DEPTH*COLS*WMAX-1:0]  opw_flat,
    output logic                        busy,
    output logic                        res_valid,
    output logic [ACCW-1:0]             res_data,
    output logic                        done
);
    import bcs_pkg::*;

    localparam int N   = ROWS * COLS;
    localparam int KW  = $clog2(DEPTH + 2);
    localparam int DRN = ROWS + COLS - 1;
    localparam int DW  = $clog2(DRN + 1);

    typedef struct packed {
        bcs_state_e     st;
        logic [PW-1:0]  bw;
        logic [PW-1:0]  bidx;
        logic [KW-1:0]  kidx;
        logic [DW-1:0]  dcnt;
        logic [N-1:0]   tok;
        logic           lastv;
        logic           rvalid;
        logic [ACCW-1:0] rdata;
        logic           done;
    } top_t;

    top_t r_d, r_q;
    logic accept;
    logic stream;

    logic colf_b [COLS];
    logic colf_v [COLS];
    logic colf_f [COLS];
    logic rowf_b [ROWS];
    logic rowf_v [ROWS];
    logic rowf_f [ROWS];

    logic cbi [ROWS][COLS];
    logic cvi [ROWS][COLS];
    logic rbi [ROWS][COLS];
    logic rai [ROWS][COLS];
    logic rfi [ROWS][COLS];
    logic cbo [ROWS][COLS];
    logic cvo [ROWS][COLS];
    logic rbo [ROWS][COLS];
    logic rao [ROWS][COLS];
    logic rfo [ROWS][COLS];

    logic [ACCW-1:0] acc_w     [N];
    logic [ACCW-1:0] snake_acc [N];

    // names observed by the bound checker
    logic [N-1:0]  tok_vec;
    logic [PW-1:0] bw_now;

    assign accept = start && (r_q.st == ST_IDLE);
    assign stream = (r_q.st == ST_RUN);

    always_comb begin
        logic inj;
        r_d = r_q;
        inj = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_RUN;
                    r_d.bw   = PW'(clamp_prec(int'(prec), WMAX));
                    r_d.bidx = '0;
                    r_d.kidx = '0;
                    r_d.done = 1'b0;
                end
            end
            ST_RUN: begin
                if (r_q.bidx == r_q.bw - 1'b1) begin
                    r_d.bidx = '0;
                    if (int'(r_q.kidx) == DEPTH) begin
                        r_d.st   = ST_DRAIN;
                        r_d.dcnt = '0;
                    end else begin
                        r_d.kidx = r_q.kidx + 1'b1;
                    end
                end else begin
                    r_d.bidx = r_q.bidx + 1'b1;
                end
            end
            ST_DRAIN: begin
                if (int'(r_q.dcnt) == DRN - 1) begin
                    r_d.st = ST_READ;
                    inj    = 1'b1;
                end else begin
                    r_d.dcnt = r_q.dcnt + 1'b1;
                end
            end
            default: begin
                if (r_q.lastv) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end
            end
        endcase
        r_d.tok    = r_q.tok << 1;
        r_d.tok[0] = inj;
        r_d.lastv  = r_q.tok[N-1];
        r_d.rvalid = |r_q.tok;
        r_d.rdata  = '0;
        for (int n = 0; n < N; n++)
            if (r_q.tok[n]) r_d.rdata = r_d.rdata | snake_acc[n];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.st != ST_IDLE);
    assign res_valid = r_q.rvalid;
    assign res_data  = r_q.rdata;
    assign done      = r_q.done;
    assign tok_vec   = r_q.tok;
    assign bw_now    = r_q.bw;

    generate
        for (genvar j = 0; j < COLS; j++) begin : g_colf
            logic [DEPTH*WMAX-1:0] cw;
            for (genvar k = 0; k < DEPTH; k++) begin : g_pick
                assign cw[k*WMAX +: WMAX] = opw_flat[(k*COLS+j)*WMAX +: WMAX];
            end
            bcs_feed #(.IS_ROW(0), .SKEW(j), .WMAX(WMAX), .DEPTH(DEPTH),
                       .KW(KW), .PW(PW)) u_feed (
                .clk(clk), .rst_n(rst_n), .cap(accept), .words_i(cw),
                .stream(stream), .kidx(r_q.kidx), .bidx(r_q.bidx), .bw(r_q.bw),
                .bit_o(colf_b[j]), .v_o(colf_v[j]), .fst_o(colf_f[j]));
        end
        for (genvar i = 0; i < ROWS; i++) begin : g_rowf
            bcs_feed #(.IS_ROW(1), .SKEW(i), .WMAX(WMAX), .DEPTH(DEPTH),
                       .KW(KW), .PW(PW)) u_feed (
                .clk(clk), .rst_n(rst_n), .cap(accept),
                .words_i(opa_flat[i*DEPTH*WMAX +: DEPTH*WMAX]),
                .stream(stream), .kidx(r_q.kidx), .bidx(r_q.bidx), .bw(r_q.bw),
                .bit_o(rowf_b[i]), .v_o(rowf_v[i]), .fst_o(rowf_f[i]));
        end
        for (genvar i = 0; i < ROWS; i++) begin : g_r
            for (genvar j = 0; j < COLS; j++) begin : g_c
                if (i == 0) begin : g_top
                    assign cbi[i][j] = colf_b[j];
                    assign cvi[i][j] = colf_v[j];
                end else begin : g_below
                    assign cbi[i][j] = cbo[i-1][j];
                    assign cvi[i][j] = cvo[i-1][j];
                end
                if (j == 0) begin : g_left
                    assign rbi[i][j] = rowf_b[i];
                    assign rai[i][j] = rowf_v[i];
                    assign rfi[i][j] = rowf_f[i];
                end else begin : g_right
                    assign rbi[i][j] = rbo[i][j-1];
                    assign rai[i][j] = rao[i][j-1];
                    assign rfi[i][j] = rfo[i][j-1];
                end
                bcs_cell #(.WMAX(WMAX), .ACCW(ACCW), .PW(PW)) u_cell (
                    .clk(clk), .rst_n(rst_n), .clr(accept), .bw(r_q.bw),
                    .c_bit_i(cbi[i][j]), .c_v_i(cvi[i][j]),
                    .r_bit_i(rbi[i][j]), .r_act_i(rai[i][j]), .r_fst_i(rfi[i][j]),
                    .c_bit_o(cbo[i][j]), .c_v_o(cvo[i][j]),
                    .r_bit_o(rbo[i][j]), .r_act_o(rao[i][j]), .r_fst_o(rfo[i][j]),
                    .acc_o(acc_w[i*COLS+j]));
            end
        end
        for (genvar n = 0; n < N; n++) begin : g_snake
            localparam int SR = n / COLS;
            localparam int SP = n % COLS;
            localparam int SC = (SR % 2 == 0) ? SP : (COLS - 1 - SP);
            assign snake_acc[n] = acc_w[SR*COLS+SC];
        end
    endgenerate

endmodule

// File: rtl/bcs_grid_chk.sv
module bcs_grid_chk #(
    parameter int N    = 16,
    parameter int WMAX = 16,
    parameter int PW   = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          res_valid,
    input logic          done,
    input logic [N-1:0]  tok,
    input logic [PW-1:0] bw
);
    assert_read_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok));

    assert_valid_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> busy);

    assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_valid) |=> busy);

    assert_done_follows_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($past(res_valid) && !busy));

    assert_done_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_prec_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (bw >= PW'(1) && bw <= PW'(WMAX)));
endmodule

bind bcs_booth_grid bcs_grid_chk #(.N(ROWS*COLS), .WMAX(WMAX), .PW($clog2(WMAX+1))) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .res_valid(res_valid), .done(done), .tok(tok_vec), .bw(bw_now));

// File: tb/tb_bcs_booth_grid.sv
`timescale 1ns/1ps
module tb_bcs_booth_grid;
    localparam int ROWS = 4, COLS = 4, DEPTH = 4, WMAX = 16;
    localparam int ACCW = 2*WMAX + $clog2(DEPTH+1);
    localparam int N = ROWS*COLS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [4:0] prec = '0;
    logic [ROWS*DEPTH*WMAX-1:0] opa_flat = '0;
    logic [DEPTH*COLS*WMAX-1:0] opw_flat = '0;
    logic busy, res_valid, done;
    logic [ACCW-1:0] res_data;

    int compared = 0;
    int mismatched = 0;
    bit fin = 0;
    longint exp_q[$];
    int res_idx = 0;

    logic [15:0] ta [ROWS][DEPTH];
    logic [15:0] tw [DEPTH][COLS];
    logic [31:0] lcg;

    always #5 clk = ~clk;

    bcs_booth_grid #(.ROWS(ROWS), .COLS(COLS), .DEPTH(DEPTH), .WMAX(WMAX)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .prec(prec),
        .opa_flat(opa_flat), .opw_flat(opw_flat), .busy(busy),
        .res_valid(res_valid), .res_data(res_data), .done(done));

    task automatic check(input bit ok, input string req, input longint got, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    function automatic longint sx(input logic [15:0] v, input int b);
        longint m;
        longint x;
        m = (longint'(1) << b) - 1;
        x = longint'(v) & m;
        if (x[b-1]) x = x - (longint'(1) << b);
        return x;
    endfunction

    task automatic fill_lcg(input logic [31:0] seed);
        lcg = seed;
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < DEPTH; k++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                ta[i][k] = lcg[31:16];
            end
        for (int k = 0; k < DEPTH; k++)
            for (int j = 0; j < COLS; j++) begin
                lcg = lcg * 32'd1103515245 + 32'd12345;
                tw[k][j] = lcg[31:16];
            end
    endtask

    task automatic fill_const(input logic [15:0] av, input logic [15:0] wv);
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < DEPTH; k++) ta[i][k] = av;
        for (int k = 0; k < DEPTH; k++)
            for (int j = 0; j < COLS; j++) tw[k][j] = wv;
    endtask

    // Driver: pushes snake-ordered expectations (R2, R3, R6) then runs the block.
    task automatic run_case(input int p, input bit poke);
        int eff;
        int lat;
        int n;
        eff = (p == 0) ? 1 : ((p > WMAX) ? WMAX : p);   // R4 rule
        for (int q = 0; q < N; q++) begin
            int r, c;
            longint s;
            r = q / COLS;
            c = (r % 2 == 0) ? (q % COLS) : (COLS - 1 - q % COLS);
            s = 0;
            for (int k = 0; k < DEPTH; k++)
                s += sx(ta[r][k], eff) * sx(tw[k][c], eff);
            exp_q.push_back(s);
        end
        for (int i = 0; i < ROWS; i++)
            for (int k = 0; k < DEPTH; k++)
                opa_flat[(i*DEPTH+k)*WMAX +: WMAX] = ta[i][k];
        for (int k = 0; k < DEPTH; k++)
            for (int j = 0; j < COLS; j++)
                opw_flat[(k*COLS+j)*WMAX +: WMAX] = tw[k][j];
        @(negedge clk);
        start = 1'b1;
        prec  = 5'(p);
        @(negedge clk);
        start = 1'b0;
        lat = (DEPTH + 1) * eff + ROWS + COLS;
        n = 0;
        while (n < lat + 4) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (res_valid) break;
            if (poke && n == 3) begin   // R8: mid-run start with other data
                start = 1'b1;
                prec = 5'd2;
                opa_flat = '1;
                opw_flat = '1;
            end
            if (poke && n == 4) start = 1'b0;
        end
        check(n == lat, "R5 latency", n, lat);
        for (int m = 1; m < N; m++) begin
            @(negedge clk);
            check(res_valid == 1'b1, "R6 consecutive results", res_valid, 1);
        end
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0 && res_valid == 1'b0, "R7 done after last",
              {done, busy, res_valid}, 3'b100);
        check(exp_q.size() == 0, "R6 result count", exp_q.size(), 0);
        repeat (2) @(negedge clk);
        check(done == 1'b1, "R7 done held", done, 1);
    endtask

    // Monitor: pops and compares each result as it appears.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            longint got;
            longint exp;
            got = longint'($signed(res_data));
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected result", got, 0);
            end else begin
                exp = exp_q.pop_front();
                check(got == exp, "R2 product", got, exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!fin) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 0 && res_valid == 0 && done == 0, "R1 reset state",
              {busy, res_valid, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 0 && res_valid == 0 && done == 0, "R1 after release",
              {busy, res_valid, done}, 0);
        fill_lcg(32'h1234_5678);  run_case(8, 1'b0);             // R2, R3
        fill_const(16'h8000, 16'h8000); run_case(16, 1'b0);      // R9 extreme
        fill_const(16'h8000, 16'h7fff); run_case(16, 1'b0);      // R9 mixed sign
        fill_lcg(32'h0bad_cafe);  run_case(1, 1'b0);             // R3 single bit
        fill_lcg(32'h5eed_0001);  run_case(5, 1'b0);             // R3 upper bits ignored
        fill_lcg(32'h7777_1111);  run_case(0, 1'b0);             // R4 zero -> 1
        fill_lcg(32'h2468_ace0);  run_case(31, 1'b0);            // R4 above max -> 16
        fill_lcg(32'h1357_9bdf);  run_case(3, 1'b1);             // R8 start while busy
        @(negedge clk);
        check(done == 1'b1 && busy == 1'b0, "R7 idle after run", {done, busy}, 2'b10);
        fin = 1;
        summary();
        $finish;
    end
endmodule